// File: doc/BRIEF.md
# Calendar Timekeeping Core

This block keeps wall-clock time and calendar date for a larger chip. It takes a single-cycle enable pulse for each period of a 32.768 kHz oscillator and divides it in two stages, first to a 512 Hz sub-second tick and then to a one-second tick. Each one-second tick advances a chain of BCD counters: seconds, minutes, hours, day of week, date, month and two-digit year. Date rollover follows the month length, and February gets a 29th day in years divisible by four. A century flag toggles whenever the year wraps from 99 to 00.

Software sees the time through a small register window holding a shadow copy of the counters. The shadow normally follows the running counters. A capture bit freezes the shadow so that a multi-byte read is coherent. A hold bit also freezes it, so that software can write a new time into it. Clearing the hold bit copies the shadow into the counters and restarts both divider stages. The counters keep running during both freeze modes. A stop input pauses the divider, and with it the clock.

Top module: `rtc_core_top`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, day of week 1, date 01, month 01 and year 00. The control register (address 0) reads 00.
- R2: Seconds advance by exactly one after OSC_PER_SUB*SUB_PER_SEC oscillator pulses, counted from reset or from a load. No earlier pulse count changes them.
- R3: While control bit 0 (capture) is 1, reads of addresses 1..7 return a frozen snapshot. Once the bit is cleared, reads follow the running time again.
- R4: While control bit 1 (hold) is 1, the time registers keep the values software writes to them, and the counters still produce one-second ticks on sec_tick_o. Writing 0 to bit 1 while it is 1 loads the time registers into the counters and clears both divider stages.
- R5: Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and carry into the day.
- R6: While osc_stop_i is 1, oscillator pulses are ignored and the time does not change.
- R7: Day of week counts 1..7 and goes from 7 back to 1 on each day carry.
- R8: Date wraps to 01 after the month's last day: 30 for months 04, 06, 09 and 11; 31 for other months; 29 for month 02 when the year is divisible by 4, otherwise 28.
- R9: Month wraps from 12 to 01 and increments the year. When the year wraps from 99 to 00, control bit 2 (century flag) toggles.
- R10: Out-of-range loaded values are not corrected. A field whose value is not its wrap value steps as a BCD digit pair (low digit 9 carries into the high digit, otherwise +1, truncated to the field width). For example, seconds go 7A to 7B and 7F to 00, with no carry into the minutes.
- R11: Register addresses are 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month and 7 year. Their widths are 7, 7, 6, 3, 6, 5 and 8 bits, and unused upper bits read 0. The control register reads {5'b0, century, hold, capture}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_pulse_i | input | 1 | One-cycle pulse per oscillator period |
| osc_stop_i | input | 1 | Active-high stop, ignores oscillator pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address for reads and writes |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the addressed register |
| sec_tick_o | output | 1 | One-cycle pulse per counted second |

## Verification
The bench builds the core with OSC_PER_SUB=4 and SUB_PER_SEC=4, so a second lasts 16 oscillator pulses. At that rate it can step two full minutes across midnight one second at a time. It can also sweep every month's end in two ordinary years, one leap year and the century year. The short divider also lets the bench count the exact pulses to a seconds change, both from a load and after a partly filled divider is cleared.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef struct packed {
      logic [6:0] sec;
      logic [6:0] min;
      logic [5:0] hour;
      logic [2:0] dow;
      logic [5:0] date;
      logic [4:0] mon;
      logic [7:0] year;
   } rtc_time_t;

   localparam rtc_time_t RTC_RESET_TIME = '{
      sec:  7'h00,
      min:  7'h00,
      hour: 6'h00,
      dow:  3'd1,
      date: 6'h01,
      mon:  5'h01,
      year: 8'h00
   };

   // BCD digit-pair step; no range correction of its input
   function automatic logic [7:0] bcd_step(input logic [7:0] v);
      if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
      else                return v + 8'h01;
   endfunction

   function automatic logic year_is_leap(input logic [7:0] y);
      if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
      else       return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
   endfunction

   function automatic logic [5:0] month_last(input logic [4:0] m, input logic leap);
      case (m)
         5'h02:                      return leap ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic tick_o
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (en_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   assign tick_o = en_i && !clr_i && (cnt_q == LAST);

   // R2: after a clear the counter restarts from zero
   a_r2_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_i) |-> (cnt_q == '0));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick_i,
   input  logic      load_i,
   input  rtc_time_t load_val_i,
   output rtc_time_t time_o,
   output logic      cf_o
);
   rtc_time_t time_q, time_nx;
   logic      cf_q;
   logic      c_min, c_hour, c_day, c_mon, c_year, c_cent;
   logic [5:0] last_d;

   assign last_d = month_last(time_q.mon, year_is_leap(time_q.year));

   always_comb begin
      time_nx = time_q;
      c_min   = 1'b0;
      c_hour  = 1'b0;
      c_day   = 1'b0;
      c_mon   = 1'b0;
      c_year  = 1'b0;
      c_cent  = 1'b0;

      c_min       = (time_q.sec == 7'h59);
      time_nx.sec = c_min ? 7'h00 : 7'(bcd_step({1'b0, time_q.sec}));

      if (c_min) begin
         c_hour      = (time_q.min == 7'h59);
         time_nx.min = c_hour ? 7'h00 : 7'(bcd_step({1'b0, time_q.min}));
      end
      if (c_hour) begin
         c_day        = (time_q.hour == 6'h23);
         time_nx.hour = c_day ? 6'h00 : 6'(bcd_step({2'b00, time_q.hour}));
      end
      if (c_day) begin
         time_nx.dow  = (time_q.dow == 3'd7) ? 3'd1 : time_q.dow + 3'd1;
         c_mon        = (time_q.date == last_d);
         time_nx.date = c_mon ? 6'h01 : 6'(bcd_step({2'b00, time_q.date}));
      end
      if (c_mon) begin
         c_year      = (time_q.mon == 5'h12);
         time_nx.mon = c_year ? 5'h01 : 5'(bcd_step({3'b000, time_q.mon}));
      end
      if (c_year) begin
         c_cent       = (time_q.year == 8'h99);
         time_nx.year = c_cent ? 8'h00 : bcd_step(time_q.year);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         time_q <= RTC_RESET_TIME;
         cf_q   <= 1'b0;
      end else if (load_i) begin
         time_q <= load_val_i;
      end else if (tick_i) begin
         time_q <= time_nx;
         cf_q   <= cf_q ^ c_cent;
      end
   end

   assign time_o = time_q;
   assign cf_o   = cf_q;

   // R5 / R10: every counted second changes the seconds field
   a_r5_sec_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_i) |=> (time_q.sec != $past(time_q.sec)));
   // R9: the century flag only changes as the year lands on 00
   a_r9_cf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cf_q != $past(cf_q)) |-> (time_q.year == 8'h00));
   // R4: a load installs exactly the offered time
   a_r4_load_applied: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load_i) |-> (time_q == $past(load_val_i)));
endmodule

// File: rtl/rtc_user_regs.sv
module rtc_user_regs
   import rtc_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   input  rtc_time_t         core_time_i,
   input  logic              core_cf_i,
   output logic [7:0]        rdata_o,
   output rtc_time_t         shadow_o,
   output logic              load_o
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_DOW  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(5);
   localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(6);
   localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(7);

   logic      capture_q, hold_q;
   rtc_time_t shadow_q;
   logic      ctrl_wr, time_wr;

   assign ctrl_wr = we_i && (addr_i == A_CTRL);
   assign time_wr = we_i && (addr_i != A_CTRL) && (addr_i <= A_YEAR);
   assign load_o  = ctrl_wr && hold_q && !wdata_i[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         capture_q <= 1'b0;
         hold_q    <= 1'b0;
         shadow_q  <= RTC_RESET_TIME;
      end else begin
         if (ctrl_wr) begin
            capture_q <= wdata_i[0];
            hold_q    <= wdata_i[1];
         end
         if (time_wr) begin
            case (addr_i)
               A_SEC:   shadow_q.sec  <= wdata_i[6:0];
               A_MIN:   shadow_q.min  <= wdata_i[6:0];
               A_HOUR:  shadow_q.hour <= wdata_i[5:0];
               A_DOW:   shadow_q.dow  <= wdata_i[2:0];
               A_DATE:  shadow_q.date <= wdata_i[5:0];
               A_MON:   shadow_q.mon  <= wdata_i[4:0];
               default: shadow_q.year <= wdata_i;
            endcase
         end else if (!capture_q && !hold_q) begin
            shadow_q <= core_time_i;
         end
      end
   end

   always_comb begin
      case (addr_i)
         A_CTRL:  rdata_o = {5'b0, core_cf_i, hold_q, capture_q};
         A_SEC:   rdata_o = {1'b0, shadow_q.sec};
         A_MIN:   rdata_o = {1'b0, shadow_q.min};
         A_HOUR:  rdata_o = {2'b0, shadow_q.hour};
         A_DOW:   rdata_o = {5'b0, shadow_q.dow};
         A_DATE:  rdata_o = {2'b0, shadow_q.date};
         A_MON:   rdata_o = {3'b0, shadow_q.mon};
         A_YEAR:  rdata_o = shadow_q.year;
         default: rdata_o = 8'h00;
      endcase
   end

   assign shadow_o = shadow_q;

   // R3: a frozen snapshot moves only through software writes
   a_r3_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(capture_q) && !$past(we_i)) |-> $stable(shadow_q));
endmodule

// File: rtl/rtc_core_top.sv
module rtc_core_top
   import rtc_pkg::*;
#(
   parameter int OSC_PER_SUB = 64,
   parameter int SUB_PER_SEC = 512,
   parameter int ADDR_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_pulse_i,
   input  logic              osc_stop_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [7:0]        reg_wdata_i,
   output logic [7:0]        reg_rdata_o,
   output logic              sec_tick_o
);
   localparam int PULSES_PER_SEC = OSC_PER_SUB * SUB_PER_SEC;

   generate
      if (OSC_PER_SUB < 2) begin : g_bad_sub
         $error("OSC_PER_SUB must be at least 2");
      end
      if (SUB_PER_SEC < 2) begin : g_bad_sec
         $error("SUB_PER_SEC must be at least 2");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must cover addresses 0..7");
      end
      if (PULSES_PER_SEC < 4) begin : g_bad_total
         $error("divider chain too short");
      end
   endgenerate

   logic      osc_en, sub_tick, one_hz, load;
   rtc_time_t core_time, shadow;
   logic      core_cf;

   assign osc_en = osc_pulse_i && !osc_stop_i;

   rtc_prescaler #(.DIV(OSC_PER_SUB)) u_sub_div (
      .clk(clk), .rst_n(rst_n), .clr_i(load), .en_i(osc_en), .tick_o(sub_tick));

   rtc_prescaler #(.DIV(SUB_PER_SEC)) u_sec_div (
      .clk(clk), .rst_n(rst_n), .clr_i(load), .en_i(sub_tick), .tick_o(one_hz));

   rtc_calendar u_cal (
      .clk(clk), .rst_n(rst_n), .tick_i(one_hz), .load_i(load),
      .load_val_i(shadow), .time_o(core_time), .cf_o(core_cf));

   rtc_user_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .core_time_i(core_time), .core_cf_i(core_cf),
      .rdata_o(reg_rdata_o), .shadow_o(shadow), .load_o(load));

   assign sec_tick_o = one_hz;

   // R6: a stopped oscillator leaves the running time untouched
   a_r6_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(osc_stop_i) && !$past(load)) |-> $stable(core_time));
   // R2: no second is counted while the oscillator path is stopped
   a_r2_no_tick_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      osc_stop_i |-> !sec_tick_o);
endmodule

// File: tb/rtc_core_top_tb_top.sv
module rtc_core_top_tb_top;
   localparam int SUB = 4;
   localparam int SEC = 4;
   localparam int PPS = SUB * SEC;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_pulse = 1'b0;
   logic       osc_stop = 1'b0;
   logic       we = 1'b0;
   logic [3:0] addr = 4'h0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       sec_tick;

   int n_chk = 0;
   int n_bad = 0;
   int n_ticks = 0;
   bit done = 1'b0;

   int cs, cm, ch, cw, cd, cmo, cy, ccf;

   always #2 clk = ~clk;

   rtc_core_top #(.OSC_PER_SUB(SUB), .SUB_PER_SEC(SEC), .ADDR_W(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .osc_pulse_i(osc_pulse), .osc_stop_i(osc_stop),
      .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .sec_tick_o(sec_tick));

   always @(posedge clk) if (sec_tick) n_ticks++;

   function automatic logic [7:0] bcd(input int v);
      return 8'((v / 10) * 16 + (v % 10));
   endfunction

   function automatic int days_in(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic model_step();
      cs++;
      if (cs == 60) begin
         cs = 0; cm++;
         if (cm == 60) begin
            cm = 0; ch++;
            if (ch == 24) begin
               ch = 0;
               cw = (cw == 7) ? 1 : cw + 1;
               cd++;
               if (cd > days_in(cmo, cy)) begin
                  cd = 1; cmo++;
                  if (cmo == 13) begin
                     cmo = 1; cy++;
                     if (cy == 100) begin cy = 0; ccf ^= 1; end
                  end
               end
            end
         end
      end
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; #1; d = rdata;
   endtask

   task automatic run_osc(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); osc_pulse = 1'b1;
      end
      @(negedge clk); osc_pulse = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic set_all(input int s, input int m, input int h, input int w,
                          input int d, input int mo, input int y);
      cs = s; cm = m; ch = h; cw = w; cd = d; cmo = mo; cy = y;
      wr(4'h0, 8'h02);
      wr(4'h1, bcd(s)); wr(4'h2, bcd(m)); wr(4'h3, bcd(h)); wr(4'h4, bcd(w));
      wr(4'h5, bcd(d)); wr(4'h6, bcd(mo)); wr(4'h7, bcd(y));
      wr(4'h0, 8'h00);
      settle();
   endtask

   task automatic chk_time(input string req);
      logic [7:0] v;
      rd(4'h1, v); chk({req, " sec"},  v, bcd(cs));
      rd(4'h2, v); chk({req, " min"},  v, bcd(cm));
      rd(4'h3, v); chk({req, " hour"}, v, bcd(ch));
      rd(4'h4, v); chk({req, " dow"},  v, bcd(cw));
      rd(4'h5, v); chk({req, " date"}, v, bcd(cd));
      rd(4'h6, v); chk({req, " mon"},  v, bcd(cmo));
      rd(4'h7, v); chk({req, " year"}, v, bcd(cy));
   endtask

   initial begin
      logic [7:0] v;
      int t0;
      int yrs [4] = '{23, 24, 0, 98};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      settle();

      // R1 reset state
      cs = 0; cm = 0; ch = 0; cw = 1; cd = 1; cmo = 1; cy = 0; ccf = 0;
      chk_time("R1");
      rd(4'h0, v); chk("R1 ctrl", v, 8'h00);

      // R11 field widths on write/readback during hold
      wr(4'h0, 8'h02);
      rd(4'h0, v); chk("R11 ctrl hold", v, 8'h02);
      wr(4'h1, 8'hFF); rd(4'h1, v); chk("R11 sec width", v, 8'h7F);
      wr(4'h3, 8'hFF); rd(4'h3, v); chk("R11 hour width", v, 8'h3F);
      wr(4'h4, 8'hFF); rd(4'h4, v); chk("R11 dow width", v, 8'h07);
      wr(4'h6, 8'hFF); rd(4'h6, v); chk("R11 mon width", v, 8'h1F);
      wr(4'h0, 8'h00);

      // R5 R7 R8: 120 single-second steps across a leap-day midnight
      set_all(0, 58, 23, 2, 28, 2, 24);
      for (int i = 0; i < 120; i++) begin
         run_osc(PPS);
         model_step();
         chk_time("R5");
      end

      // R2 exact pulse count per second
      set_all(10, 0, 0, 1, 1, 1, 0);
      run_osc(PPS - 1);
      rd(4'h1, v); chk("R2 early", v, bcd(10));
      run_osc(1);
      rd(4'h1, v); chk("R2 on count", v, bcd(11));

      // R4 load clears a partly filled divider
      run_osc(PPS / 2 + 2);
      set_all(20, 0, 0, 1, 1, 1, 0);
      run_osc(PPS - 1);
      rd(4'h1, v); chk("R4 divider cleared", v, bcd(20));
      run_osc(1);
      rd(4'h1, v); chk("R4 after clear", v, bcd(21));

      // R4 counters keep running while held; load takes written value
      set_all(5, 30, 12, 3, 15, 6, 50);
      wr(4'h0, 8'h02);
      t0 = n_ticks;
      run_osc(3 * PPS);
      chk("R4 ticks during hold", 8'(n_ticks - t0), 8'd3);
      rd(4'h1, v); chk("R4 held value", v, bcd(5));
      wr(4'h1, bcd(40));
      wr(4'h0, 8'h00);
      settle();
      cs = 40;
      chk_time("R4 loaded");

      // R3 capture freezes the snapshot
      wr(4'h0, 8'h01);
      run_osc(3 * PPS);
      model_step(); model_step(); model_step();
      rd(4'h1, v); chk("R3 frozen", v, bcd(40));
      rd(4'h0, v); chk("R3 ctrl", v, 8'h01);
      wr(4'h0, 8'h00);
      settle();
      chk_time("R3 released");

      // R6 stop input
      osc_stop = 1'b1;
      run_osc(3 * PPS);
      settle();
      chk_time("R6 stopped");
      osc_stop = 1'b0;
      run_osc(PPS);
      model_step();
      chk_time("R6 resumed");

      // R7 R8 R9 month ends over several years
      foreach (yrs[k]) begin
         for (int mo = 1; mo <= 12; mo++) begin
            set_all(59, 59, 23, 7, days_in(mo, yrs[k]), mo, yrs[k]);
            run_osc(PPS);
            model_step();
            chk_time("R8 month end");
            set_all(59, 59, 23, 3, days_in(mo, yrs[k]) - 1, mo, yrs[k]);
            run_osc(PPS);
            model_step();
            chk_time("R8 day before end");
         end
      end

      // R9 century flag
      rd(4'h0, v); chk("R9 flag before", v, 8'h00);
      set_all(59, 59, 23, 5, 31, 12, 99);
      run_osc(PPS);
      model_step();
      chk_time("R9 century wrap");
      rd(4'h0, v); chk("R9 flag set", v, 8'h04);

      // R10 invalid values step without correction
      wr(4'h0, 8'h02); wr(4'h1, 8'h7A); wr(4'h0, 8'h00); settle();
      run_osc(PPS);
      rd(4'h1, v); chk("R10 7A step", v, 8'h7B);
      wr(4'h0, 8'h02); wr(4'h1, 8'h7F); wr(4'h2, 8'h05); wr(4'h0, 8'h00); settle();
      run_osc(PPS);
      rd(4'h1, v); chk("R10 7F wrap", v, 8'h00);
      rd(4'h2, v); chk("R10 no carry", v, 8'h05);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule